// File: doc/BRIEF.md
# OSD Display-RAM Write Format Decoder

This block sits behind a serial front end that hands it one byte at a time, plus a strobe that marks the start of each transfer. It sorts the bytes into row headers, column headers and data, following three packing formats. From them it produces write requests for an on-screen-display memory of 15 rows by 30 columns. Each memory cell has two planes: a 9-bit character code and an 8-bit attribute.

The block keeps the current row, the current column, the selected plane and the latched ninth code bit. Each write request carries the row, the column, the plane and a 9-bit data word.

Format choice is one-way. The row-per-write and row-shared formats can hand over to each other, or enter the burst format. Once the burst format is entered, only a new transfer leaves it. In burst mode every byte is data, and the address steps on by itself after each write.

Top module: `osd_wr_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, `wr_vld_o` is 0 and the decoder expects a row byte.
- R2: When a row or a column is expected, a byte with bit 7 set is a row header. Bits 4..0 become the row. Bit 5 picks the plane: 0 for code, 1 for attribute. A column is expected next.
- R3: When a column is expected, a byte with bit 7 clear is a column header. Bits 4..0 become the column and bit 5 is latched as the ninth code bit. Bit 6 picks the mode: 0 expects a single data byte next, 1 enters burst mode.
- R4: A data byte produces `wr_vld_o`=1 exactly one cycle after it is accepted, carrying the current row, column and plane. On the code plane the data word is {latched bit, byte}.
- R5: On the attribute plane the data word is {0, byte}, whatever bit 5 of the column header was.
- R6: After a non-burst data byte, a byte with bit 7 set starts a new row header. A byte with bit 7 clear is a new column header on the kept row, and its bit 6 again picks the mode.
- R7: In burst mode the column steps by one after every data byte. After column 29 it returns to 0 and the row advances. After row 14 the row returns to 0.
- R8: In burst mode every byte is data, including bytes with bit 7 set. Nothing but the start strobe leaves burst mode.
- R9: In burst mode the latched ninth code bit applies to every data byte, until a new column header is accepted.
- R10: The start strobe returns the decoder to expecting a row byte. A byte presented in the same cycle as the strobe is dropped. While a row is expected, a byte with bit 7 clear is discarded, and no write follows either event.
- R11: A data byte whose row is 15 or more, or whose column is 30 or more, produces no write request. In burst mode the address still steps on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-transfer strobe |
| byte_vld_i | input | 1 | Byte qualifier |
| byte_i | input | 8 | Received byte |
| wr_vld_o | output | 1 | Write request |
| wr_row_o | output | 5 | Write row |
| wr_col_o | output | 5 | Write column |
| wr_plane_o | output | 1 | Plane: 0 code, 1 attribute |
| wr_data_o | output | 9 | Write data word |

## Verification
Every write request appears in the cycle after the clock edge that accepted its data byte. Header bytes, discarded bytes and the start strobe change only internal state, so their effect shows up in the address carried by later writes, or in `wr_vld_o` staying low in the following cycle.

The bench drives a byte on a falling edge and runs its reference model on it at once. It compares the design's outputs at the next falling edge, after the single register stage. Every cycle is checked this way, and the address fields are compared only when a write is expected.

// File: rtl/osd_dec_pkg.sv
package osd_dec_pkg;
  localparam int HDR_BIT  = 7;  // set: row header
  localparam int MODE_BIT = 6;  // column header: 1 = burst
  localparam int SEL_BIT  = 5;  // row: plane, column: code bit 8

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WANT_COL,
    ST_WANT_DATA,
    ST_AFTER_DATA,
    ST_BURST
  } fmt_state_e;
endpackage

// File: rtl/osd_fmt_fsm.sv
module osd_fmt_fsm
  import osd_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       byte_vld_i,
  input  logic [1:0] hdr_i,      // byte bits 7..6
  output logic       row_ld_o,
  output logic       col_ld_o,
  output logic       data_ev_o,
  output logic       step_o
);
  fmt_state_e cur_q, nxt_d;
  logic is_row, is_burst;

  assign is_row   = hdr_i[1];
  assign is_burst = hdr_i[0];

  always_comb begin
    nxt_d     = cur_q;
    row_ld_o  = 1'b0;
    col_ld_o  = 1'b0;
    data_ev_o = 1'b0;
    step_o    = 1'b0;
    if (start_i) begin
      nxt_d = ST_IDLE;
    end else if (byte_vld_i) begin
      case (cur_q)
        ST_IDLE: begin
          if (is_row) begin
            row_ld_o = 1'b1;
            nxt_d    = ST_WANT_COL;
          end
        end
        ST_WANT_COL, ST_AFTER_DATA: begin
          if (is_row) begin
            row_ld_o = 1'b1;
            nxt_d    = ST_WANT_COL;
          end else begin
            col_ld_o = 1'b1;
            nxt_d    = is_burst ? ST_BURST : ST_WANT_DATA;
          end
        end
        ST_WANT_DATA: begin
          data_ev_o = 1'b1;
          nxt_d     = ST_AFTER_DATA;
        end
        ST_BURST: begin
          data_ev_o = 1'b1;
          step_o    = 1'b1;
        end
        default: nxt_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= ST_IDLE;
    else        cur_q <= nxt_d;
  end

  // R8: burst is left only through the start strobe
  assert_burst_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_BURST && !start_i) |=> (cur_q == ST_BURST));

  // R10: a non-header byte while idle leaves the decoder idle
  assert_idle_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_IDLE && byte_vld_i && !is_row && !start_i) |=> (cur_q == ST_IDLE));

  // R10: the strobe always lands in idle
  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cur_q == ST_IDLE));
endmodule

// File: rtl/osd_addr_trk.sv
module osd_addr_trk #(
  parameter int ROWS   = 15,
  parameter int COLS   = 30,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_ld_i,
  input  logic              col_ld_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_i,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic              plane_o,
  output logic              fbit_o
);
  localparam logic [ADDR_W-1:0] ROW_LAST = ADDR_W'(ROWS - 1);
  localparam logic [ADDR_W-1:0] COL_LAST = ADDR_W'(COLS - 1);
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

  logic [ADDR_W-1:0] row_q, row_d, col_q, col_d;
  logic              plane_q, plane_d, fbit_q, fbit_d;

  always_comb begin
    row_d   = row_q;
    col_d   = col_q;
    plane_d = plane_q;
    fbit_d  = fbit_q;
    if (row_ld_i) begin
      row_d   = addr_i;
      plane_d = sel_i;
    end
    if (col_ld_i) begin
      col_d  = addr_i;
      fbit_d = sel_i;
    end
    if (step_i) begin
      if (col_q >= COL_LAST) begin
        col_d = '0;
        row_d = (row_q >= ROW_LAST) ? '0 : row_q + ONE;
      end else begin
        col_d = col_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      plane_q <= 1'b0;
      fbit_q  <= 1'b0;
    end else begin
      row_q   <= row_d;
      col_q   <= col_d;
      plane_q <= plane_d;
      fbit_q  <= fbit_d;
    end
  end

  assign row_o   = row_q;
  assign col_o   = col_q;
  assign plane_o = plane_q;
  assign fbit_o  = fbit_q;

  // R7: column wraps at the last column and the row advances
  assert_col_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && col_q == COL_LAST && row_q < ROW_LAST) |=>
      (col_q == '0 && row_q == $past(row_q) + ONE));

  // R7: row wraps after the last row
  assert_row_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && col_q == COL_LAST && row_q == ROW_LAST) |=> (col_q == '0 && row_q == '0));

  // R7: plain step keeps the row
  assert_col_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && col_q < COL_LAST) |=> (col_q == $past(col_q) + ONE && $stable(row_q)));

  // R9: burst steps keep the latched code bit
  assert_fbit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !col_ld_i) |=> $stable(fbit_q));
endmodule

// File: rtl/osd_wr_decoder.sv
module osd_wr_decoder
  import osd_dec_pkg::*;
#(
  parameter int ROWS   = 15,
  parameter int COLS   = 30,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              wr_vld_o,
  output logic [ADDR_W-1:0] wr_row_o,
  output logic [ADDR_W-1:0] wr_col_o,
  output logic              wr_plane_o,
  output logic [DATA_W:0]   wr_data_o
);
  localparam logic [ADDR_W-1:0] ROW_LIM = ADDR_W'(ROWS);
  localparam logic [ADDR_W-1:0] COL_LIM = ADDR_W'(COLS);

  logic              row_ld, col_ld, data_ev, step;
  logic [ADDR_W-1:0] cur_row, cur_col;
  logic              cur_plane, cur_fbit, in_range;

  logic              vld_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              plane_q;
  logic [DATA_W:0]   data_q, data_d;

  osd_fmt_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .hdr_i      ({byte_i[HDR_BIT], byte_i[MODE_BIT]}),
    .row_ld_o   (row_ld),
    .col_ld_o   (col_ld),
    .data_ev_o  (data_ev),
    .step_o     (step)
  );

  osd_addr_trk #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_ld_i (row_ld),
    .col_ld_i (col_ld),
    .step_i   (step),
    .addr_i   (byte_i[ADDR_W-1:0]),
    .sel_i    (byte_i[SEL_BIT]),
    .row_o    (cur_row),
    .col_o    (cur_col),
    .plane_o  (cur_plane),
    .fbit_o   (cur_fbit)
  );

  assign in_range = (cur_row < ROW_LIM) && (cur_col < COL_LIM);
  assign data_d   = cur_plane ? {1'b0, byte_i} : {cur_fbit, byte_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= data_ev && in_range;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      plane_q <= 1'b0;
      data_q  <= '0;
    end else if (data_ev) begin
      row_q   <= cur_row;
      col_q   <= cur_col;
      plane_q <= cur_plane;
      data_q  <= data_d;
    end
  end

  assign wr_vld_o   = vld_q;
  assign wr_row_o   = row_q;
  assign wr_col_o   = col_q;
  assign wr_plane_o = plane_q;
  assign wr_data_o  = data_q;

  // R11: no request leaves with an address outside the array
  assert_addr_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld_o |-> (wr_row_o < ROW_LIM && wr_col_o < COL_LIM));

  // R5: attribute writes carry a clear top bit
  assert_attr_top_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld_o && wr_plane_o) |-> !wr_data_o[DATA_W]);

  // R10: the strobe is never followed by a write
  assert_start_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !wr_vld_o);

  // R4: a write follows only an accepted byte
  assert_write_needs_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld_i |=> !wr_vld_o);
endmodule

// File: tb/tb_osd_wr_decoder.sv
module tb_osd_wr_decoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, byte_vld_i;
  logic [7:0] byte_i;
  logic       wr_vld_o, wr_plane_o;
  logic [4:0] wr_row_o, wr_col_o;
  logic [8:0] wr_data_o;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // reference model state
  int mst, mrow, mcol, mplane, mb8;
  int e_vld, e_row, e_col, e_plane, e_data;

  always #4 clk = ~clk;

  osd_wr_decoder dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .wr_vld_o(wr_vld_o), .wr_row_o(wr_row_o), .wr_col_o(wr_col_o),
    .wr_plane_o(wr_plane_o), .wr_data_o(wr_data_o)
  );

  task automatic compare();
    bit bad;
    checks++;
    bad = (int'(wr_vld_o) != e_vld);
    if (e_vld == 1)
      bad = bad || int'(wr_row_o) != e_row || int'(wr_col_o) != e_col ||
            int'(wr_plane_o) != e_plane || int'(wr_data_o) != e_data;
    if (bad) begin
      fails++;
      $display("FAIL %s: got vld=%0d row=%0d col=%0d pl=%0d data=%03h exp vld=%0d row=%0d col=%0d pl=%0d data=%03h",
               tag, wr_vld_o, wr_row_o, wr_col_o, wr_plane_o, wr_data_o,
               e_vld, e_row, e_col, e_plane, e_data);
    end
  endtask

  task automatic model_write(input int b);
    if (mrow < 15 && mcol < 30) begin
      e_vld = 1; e_row = mrow; e_col = mcol; e_plane = mplane;
      e_data = mplane ? b : (mb8 * 256 + b);
    end
  endtask

  task automatic model_step(input int st, input int vld, input int b);
    e_vld = 0;
    if (st != 0) mst = 0;
    else if (vld != 0) begin
      case (mst)
        0: if (b >= 128) begin mrow = b % 32; mplane = (b / 32) % 2; mst = 1; end
        1, 3: begin
          if (b >= 128) begin mrow = b % 32; mplane = (b / 32) % 2; mst = 1; end
          else begin
            mcol = b % 32; mb8 = (b / 32) % 2;
            mst = ((b / 64) % 2 == 1) ? 4 : 2;
          end
        end
        2: begin model_write(b); mst = 3; end
        default: begin
          model_write(b);
          if (mcol >= 29) begin
            mcol = 0;
            mrow = (mrow >= 14) ? 0 : mrow + 1;
          end else mcol = mcol + 1;
        end
      endcase
    end
  endtask

  // one cycle: check the previous result, then present new inputs
  task automatic cyc(input int st, input int vld, input int b);
    @(negedge clk);
    compare();
    start_i    = st[0];
    byte_vld_i = vld[0];
    byte_i     = b[7:0];
    model_step(st, vld, b);
  endtask

  task automatic put(input int b);
    cyc(0, 1, b);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got running exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; byte_vld_i = 1'b0; byte_i = 8'h00;
    mst = 0; mrow = 0; mcol = 0; mplane = 0; mb8 = 0;
    e_vld = 0; e_row = 0; e_col = 0; e_plane = 0; e_data = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0);

    tag = "R10";                 // discarded while a row is expected
    put(8'h05); put(8'h41); cyc(0, 0, 0);

    tag = "R2";                  // format a: row 3 code plane, column 5 bit8
    put(8'h83); put(8'h25);
    tag = "R4";
    put(8'h41); cyc(0, 0, 0);
    tag = "R3";
    put(8'h84); put(8'h02); put(8'h7F); cyc(0, 0, 0);

    tag = "R6";                  // format b on kept row 4
    put(8'h07); put(8'h10); put(8'h28); put(8'hAA);
    put(8'h86); put(8'h01); put(8'h33); cyc(0, 0, 0);

    tag = "R5";                  // attribute plane ignores column bit5
    put(8'hA2); put(8'h3C); put(8'hF0); put(8'h1D); put(8'h0F); cyc(0, 0, 0);

    tag = "R11";                 // out of range: row 15, column 31
    put(8'h8F); put(8'h01); put(8'h11);
    put(8'h81); put(8'h1F); put(8'h22); cyc(0, 0, 0);

    tag = "R7";                  // burst from row 14 column 27 with bit8
    put(8'h8E); put(8'h7B);
    for (int i = 0; i < 5; i++) put(16 + i);
    tag = "R8";
    put(8'h85); put(8'hC3); put(8'h00);
    tag = "R9";
    put(8'h12); cyc(0, 0, 0); put(8'h34);

    tag = "R10";                 // strobe with a byte in the same cycle
    cyc(1, 1, 8'h99); put(8'h44); put(8'h81); put(8'h03); put(8'h55);
    cyc(1, 0, 0); put(8'h66); cyc(0, 0, 0);

    tag = "R7";                  // long burst across the whole array
    put(8'h80); put(8'h40);
    for (int i = 0; i < 460; i++) put(i % 256);
    cyc(1, 0, 0);

    tag = "R4";                  // mixed random stream
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 255));
      cyc(($urandom_range(0, 63) == 0) ? 1 : 0, ($urandom_range(0, 3) != 0) ? 1 : 0, r);
    end
    cyc(0, 0, 0); cyc(0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule